// File: doc/BRIEF.md
# PS/2 Pointing Device Command Engine

This block is the device half of a PS/2 pointing device, placed behind the line serializer. It accepts command bytes from the host one at a time. It also accepts motion deltas for X, Y and wheel, plus five button levels. It writes response bytes and movement packets into an internal byte queue, which the serializer drains through a valid/ready output.

The engine holds the device state: reporting on or off, 2:1 scaling, resolution and sample rate. It also holds the extension mode. That mode starts as plain 3-byte packets. It moves to a 4-byte wheel packet after one special run of sample-rate writes, and to a five-button packet after a second run. The device ID that the engine reports follows the mode. Motion is summed between packets, with saturation. Each packet clamps the sums to the ranges the packet can carry and flags any overflow. The engine starts a packet or a response only when the queue has room for all of it, so the bytes of one reply always stay together.

Top module: `ps2_ptr_engine`

## Requirements
- R1: After reset the output is idle, `cmd_ready` is 1, reporting and scaling are off, the mode is plain, the resolution is 0x02 and the sample rate is 0x64.
- R2: Each accepted host byte that is a known command, or the parameter of one, is answered with 0xFA before any other byte of its reply. An unknown command (for example 0x00 or 0xF0) is answered with the single byte 0xFE.
- R3: After 0xE8 or 0xF3, the next host byte is a parameter and is acknowledged with 0xFA: it becomes the resolution (after 0xE8) or the sample rate (after 0xF3). A parameter of 0xFF performs the full reset of R6 instead, with the reply 0xFA 0xAA 0x00.
- R4: 0xE6 clears scaling and 0xE7 sets it. 0xF4 turns reporting on and 0xF5 turns it off. 0xEA acknowledges only. Motion that arrives while reporting is off is discarded.
- R5: 0xE9 returns 0xFA and then three bytes. The first is the status byte: bit 5 scaling, bit 4 reporting, bit 2 left button (btn[0]), bit 1 middle button (btn[2]), bit 0 right button (btn[1]). The second is the resolution and the third is the sample rate.
- R6: 0xFF returns 0xFA 0xAA 0x00. 0xF6 returns 0xFA alone. Both turn reporting and scaling off, return the mode to plain, and restore resolution 0x02 and sample rate 0x64.
- R7: 0xF2 returns 0xFA and then the ID: 0x00 in plain mode, 0x03 in wheel mode, 0x04 in five-button mode.
- R8: Every accepted host byte enters a six-byte history. If the history reads F3 C8 F3 64 F3 50 in plain mode, the mode becomes wheel. If it reads F3 C8 F3 C8 F3 50 in wheel mode, the mode becomes five-button.
- R9: Packet byte 0 is {Y overflow, X overflow, Y sign, X sign, 1, btn[2], btn[1], btn[0]}. X and Y are clamped to -256..255, and the overflow bit is set when the clamp acts. Bytes 1 and 2 are the low 8 bits of the clamped X and Y.
- R10: The wheel delta is clamped to -8..7. In wheel mode, packet byte 3 is that value sign-extended to 8 bits. In five-button mode, byte 3 is {00, btn[4], btn[3], wheel[3:0]}. Plain mode packets have 3 bytes.
- R11: With reporting on, a packet is sent when a summed delta is nonzero or the buttons differ from those last sent, and at no other time. Each packet clears the sums. 0xEB returns 0xFA and then one packet on demand.
- R12: The output byte holds steady while `out_ready` is low. `cmd_ready` is high only when no reply is being loaded and the queue has at least 5 free places. A packet waits until the queue has room for the whole packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host byte present |
| cmd_data | input | 8 | Host command or parameter byte |
| cmd_ready | output | 1 | Engine accepts a host byte this cycle |
| mv_valid | input | 1 | Motion deltas present this cycle |
| mv_dx | input | IN_W | Signed X delta |
| mv_dy | input | IN_W | Signed Y delta (packet convention) |
| mv_dz | input | IN_W | Signed wheel delta |
| btn | input | 5 | Button levels: left, right, middle, fourth, fifth |
| out_valid | output | 1 | Queue holds a byte |
| out_data | output | 8 | Byte at the head of the queue |
| out_ready | input | 1 | Serializer takes the head byte |

## Verification
Motion is applied as single pulses. Some deltas are small and signed, and some exceed the range on the positive or negative side. Together they separate correct sign bits, clamping and overflow flags from plain truncation. Button-only changes and idle periods show that packets come only from real changes, and a pulse sent while reporting is off shows that such motion is discarded rather than held. The two special sample-rate runs are driven in order, each followed by an ID read and by wheel deltas in range and beyond the clamp. These tell the plain, wheel and five-button packet layouts apart. A period with the output stalled, filled by a status reply and then a packet, checks that `cmd_ready` drops and that the stalled byte holds steady and in order. Defaults, the reset run (also sent in the parameter slot) and unknown codes are checked through status and ID reads.

// File: rtl/ps2e_pkg.sv
package ps2e_pkg;
   localparam logic [7:0] RSP_ACK    = 8'hFA;
   localparam logic [7:0] RSP_RESEND = 8'hFE;
   localparam logic [7:0] RSP_BATOK  = 8'hAA;

   localparam logic [7:0] C_SCALE1   = 8'hE6;
   localparam logic [7:0] C_SCALE2   = 8'hE7;
   localparam logic [7:0] C_SETRES   = 8'hE8;
   localparam logic [7:0] C_STATUS   = 8'hE9;
   localparam logic [7:0] C_STREAM   = 8'hEA;
   localparam logic [7:0] C_READ     = 8'hEB;
   localparam logic [7:0] C_GETID    = 8'hF2;
   localparam logic [7:0] C_SETRATE  = 8'hF3;
   localparam logic [7:0] C_ENABLE   = 8'hF4;
   localparam logic [7:0] C_DISABLE  = 8'hF5;
   localparam logic [7:0] C_DEFAULT  = 8'hF6;
   localparam logic [7:0] C_RESET    = 8'hFF;

   localparam logic [7:0] RES_DEF    = 8'h02;
   localparam logic [7:0] RATE_DEF   = 8'h64;

   localparam logic [47:0] SEQ_WHEEL = 48'hF3C8_F364_F350;
   localparam logic [47:0] SEQ_FIVE  = 48'hF3C8_F3C8_F350;

   localparam int MAX_BURST = 5;

   typedef enum logic [1:0] {
      XM_PLAIN = 2'd0,
      XM_WHEEL = 2'd1,
      XM_FIVE  = 2'd2
   } xmode_e;
endpackage

// File: rtl/ps2e_fifo.sv
module ps2e_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic          nonempty,
   output logic [CW-1:0] count
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_p, rd_p;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_p  <= '0;
         rd_p  <= '0;
         count <= '0;
      end else begin
         if (push) wr_p <= step(wr_p);
         if (pop)  rd_p <= step(rd_p);
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_p] <= wdata;
   end

   assign rdata    = mem[rd_p];
   assign nonempty = (count != '0);
endmodule

// File: rtl/ps2e_pkt_fmt.sv
module ps2e_pkt_fmt
   import ps2e_pkg::*;
#(
   parameter int ACC_W     = 12,
   parameter bit ALLOW_EXT = 1'b1
) (
   input  logic signed [ACC_W-1:0] ax,
   input  logic signed [ACC_W-1:0] ay,
   input  logic signed [ACC_W-1:0] az,
   input  logic [4:0]              btn,
   input  xmode_e                  mode,
   output logic [3:0][7:0]         pkt,
   output logic [2:0]              plen
);
   localparam logic signed [ACC_W-1:0] XY_HI = ACC_W'(255);
   localparam logic signed [ACC_W-1:0] XY_LO = ACC_W'(-256);
   localparam logic signed [ACC_W-1:0] Z_HI  = ACC_W'(7);
   localparam logic signed [ACC_W-1:0] Z_LO  = ACC_W'(-8);

   logic signed [ACC_W-1:0] xc, yc, zc;
   logic ovx, ovy, mid;

   always_comb begin
      ovx = 1'b0; ovy = 1'b0;
      xc = ax; yc = ay; zc = az;
      if (ax > XY_HI) begin xc = XY_HI; ovx = 1'b1; end
      else if (ax < XY_LO) begin xc = XY_LO; ovx = 1'b1; end
      if (ay > XY_HI) begin yc = XY_HI; ovy = 1'b1; end
      else if (ay < XY_LO) begin yc = XY_LO; ovy = 1'b1; end
      if (az > Z_HI) zc = Z_HI;
      else if (az < Z_LO) zc = Z_LO;
   end

   assign mid = ALLOW_EXT ? btn[2] : 1'b0;

   always_comb begin
      pkt[0] = {ovy, ovx, ay[ACC_W-1], ax[ACC_W-1], 1'b1, mid, btn[1], btn[0]};
      pkt[1] = xc[7:0];
      pkt[2] = yc[7:0];
      unique case (mode)
         XM_FIVE:  pkt[3] = {2'b00, btn[4], btn[3], zc[3:0]};
         XM_WHEEL: pkt[3] = {{4{zc[3]}}, zc[3:0]};
         default:  pkt[3] = 8'h00;
      endcase
      plen = (mode == XM_PLAIN) ? 3'd3 : 3'd4;
   end
endmodule

// File: rtl/ps2e_magic.sv
module ps2e_magic
   import ps2e_pkg::*;
#(
   parameter bit ENABLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe,
   input  logic [7:0] byte_in,
   output logic       hit_wheel,
   output logic       hit_five
);
   generate
      if (ENABLE) begin : g_on
         logic [4:0][7:0] hist;
         logic [47:0]     window;
         assign window = {hist, byte_in};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      hist <= '0;
            else if (strobe) hist <= {hist[3:0], byte_in};
         end
         assign hit_wheel = strobe && (window == SEQ_WHEEL);
         assign hit_five  = strobe && (window == SEQ_FIVE);
      end else begin : g_off
         logic unused_in;
         assign unused_in = &{1'b0, clk, rst_n, strobe, byte_in};
         assign hit_wheel = 1'b0;
         assign hit_five  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ps2_ptr_engine.sv
module ps2_ptr_engine
   import ps2e_pkg::*;
#(
   parameter int IN_W      = 10,
   parameter int ACC_W     = 12,
   parameter int DEPTH     = 8,
   parameter bit ALLOW_EXT = 1'b1,
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic [7:0]      cmd_data,
   output logic            cmd_ready,
   input  logic            mv_valid,
   input  logic [IN_W-1:0] mv_dx,
   input  logic [IN_W-1:0] mv_dy,
   input  logic [IN_W-1:0] mv_dz,
   input  logic [4:0]      btn,
   output logic            out_valid,
   output logic [7:0]      out_data,
   input  logic            out_ready
);
   if (DEPTH < MAX_BURST) begin : g_bad_depth
      $error("DEPTH must hold the longest reply");
   end
   if (ACC_W <= IN_W || ACC_W < 10) begin : g_bad_acc
      $error("ACC_W must exceed IN_W and cover the packet range");
   end

   logic             busy;
   logic [4:0][7:0]  burst;
   logic [2:0]       blen, bidx;
   logic             pend, pend_rate;
   logic             enabled, scaled;
   logic [7:0]       res, rate;
   xmode_e           mode;
   logic signed [ACC_W-1:0] ax, ay, az;
   logic [4:0]       btn_sent;

   logic             q_push;
   logic [7:0]       q_wdata;
   logic [CW-1:0]    q_count;
   logic [3:0][7:0]  pkt;
   logic [2:0]       plen;
   logic             hit_wheel, hit_five;
   logic             cmd_fire, launch, change;
   int               q_free;

   logic [4:0][7:0]  d_burst;
   logic [2:0]       d_len;
   logic             d_take, d_rst, d_en, d_sc, d_pend, d_kind;
   logic [7:0]       d_res, d_rate, stat, id_byte;

   function automatic logic signed [ACC_W-1:0] sat_add(
      input logic signed [ACC_W-1:0] a, input logic [IN_W-1:0] d);
      logic signed [ACC_W:0] s;
      s = {a[ACC_W-1], a} + {{(ACC_W + 1 - IN_W){d[IN_W-1]}}, d};
      if (s[ACC_W] != s[ACC_W-1])
         return s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
      return s[ACC_W-1:0];
   endfunction

   ps2e_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(q_push), .wdata(q_wdata),
      .pop(out_valid && out_ready), .rdata(out_data),
      .nonempty(out_valid), .count(q_count));

   ps2e_pkt_fmt #(.ACC_W(ACC_W), .ALLOW_EXT(ALLOW_EXT)) u_fmt (
      .ax(ax), .ay(ay), .az(az), .btn(btn), .mode(mode),
      .pkt(pkt), .plen(plen));

   ps2e_magic #(.ENABLE(ALLOW_EXT)) u_magic (
      .clk(clk), .rst_n(rst_n), .strobe(cmd_fire), .byte_in(cmd_data),
      .hit_wheel(hit_wheel), .hit_five(hit_five));

   assign q_free    = DEPTH - int'(q_count);
   assign cmd_ready = !busy && (q_free >= MAX_BURST);
   assign cmd_fire  = cmd_valid && cmd_ready;
   assign change    = (ax != '0) || (ay != '0) || (az != '0) || (btn != btn_sent);
   assign launch    = !busy && !cmd_fire && enabled && change && (q_free >= int'(plen));
   assign q_push    = busy;
   assign q_wdata   = burst[bidx];

   assign stat    = {2'b00, scaled, enabled, 1'b0, btn[0],
                     ALLOW_EXT ? btn[2] : 1'b0, btn[1]};
   assign id_byte = (mode == XM_FIVE) ? 8'h04 : (mode == XM_WHEEL) ? 8'h03 : 8'h00;

   always_comb begin
      d_burst = '0;
      d_len   = 3'd1;
      d_take  = 1'b0;
      d_rst   = 1'b0;
      d_en    = enabled;
      d_sc    = scaled;
      d_pend  = 1'b0;
      d_kind  = pend_rate;
      d_res   = res;
      d_rate  = rate;
      if (launch) begin
         d_burst[3:0] = pkt;
         d_len        = plen;
         d_take       = 1'b1;
      end else if (cmd_fire) begin
         d_burst[0] = RSP_ACK;
         if (pend) begin
            if (cmd_data == C_RESET) begin
               d_burst[1] = RSP_BATOK;
               d_len      = 3'd3;
               d_rst      = 1'b1;
            end else if (pend_rate) d_rate = cmd_data;
            else                    d_res  = cmd_data;
         end else begin
            unique case (cmd_data)
               C_SCALE1:  d_sc = 1'b0;
               C_SCALE2:  d_sc = 1'b1;
               C_SETRES:  begin d_pend = 1'b1; d_kind = 1'b0; end
               C_SETRATE: begin d_pend = 1'b1; d_kind = 1'b1; end
               C_STATUS:  begin
                  d_burst[3:1] = {rate, res, stat};
                  d_len        = 3'd4;
               end
               C_STREAM:  ;
               C_READ:    begin
                  d_burst[4:1] = pkt;
                  d_len        = plen + 3'd1;
                  d_take       = 1'b1;
               end
               C_GETID:   begin d_burst[1] = id_byte; d_len = 3'd2; end
               C_ENABLE:  d_en = 1'b1;
               C_DISABLE: d_en = 1'b0;
               C_DEFAULT: d_rst = 1'b1;
               C_RESET:   begin
                  d_burst[1] = RSP_BATOK;
                  d_len      = 3'd3;
                  d_rst      = 1'b1;
               end
               default:   d_burst[0] = RSP_RESEND;
            endcase
         end
         if (d_rst) begin
            d_en = 1'b0; d_sc = 1'b0; d_res = RES_DEF; d_rate = RATE_DEF;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; burst <= '0; blen <= '0; bidx <= '0;
         pend <= 1'b0; pend_rate <= 1'b0;
         enabled <= 1'b0; scaled <= 1'b0;
         res <= RES_DEF; rate <= RATE_DEF; mode <= XM_PLAIN;
      end else begin
         if (busy) begin
            bidx <= bidx + 3'd1;
            if (bidx == blen - 3'd1) busy <= 1'b0;
         end else if (cmd_fire || launch) begin
            busy  <= 1'b1;
            burst <= d_burst;
            blen  <= d_len;
            bidx  <= '0;
         end
         if (cmd_fire) begin
            pend      <= d_pend;
            pend_rate <= d_kind;
            enabled   <= d_en;
            scaled    <= d_sc;
            res       <= d_res;
            rate      <= d_rate;
            if (d_rst)                               mode <= XM_PLAIN;
            else if (hit_wheel && mode == XM_PLAIN)  mode <= XM_WHEEL;
            else if (hit_five && mode == XM_WHEEL)   mode <= XM_FIVE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ax <= '0; ay <= '0; az <= '0; btn_sent <= '0;
      end else begin
         logic signed [ACC_W-1:0] bx, by, bz;
         bx = d_take ? '0 : ax;
         by = d_take ? '0 : ay;
         bz = d_take ? '0 : az;
         if (mv_valid && enabled) begin
            ax <= sat_add(bx, mv_dx);
            ay <= sat_add(by, mv_dy);
            az <= sat_add(bz, mv_dz);
         end else begin
            ax <= bx; ay <= by; az <= bz;
         end
         if (d_take) btn_sent <= btn;
      end
   end
endmodule

// File: rtl/ps2e_chk.sv
module ps2e_chk #(
   parameter int DEPTH = 8,
   parameter int CW    = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic          out_valid,
   input logic          out_ready,
   input logic [7:0]    out_data,
   input logic          q_push,
   input logic [7:0]    q_wdata,
   input logic [CW-1:0] q_count,
   input logic          launch
);
   // R12: a stalled head byte stays put
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R12: an accepted byte blocks the next one while its reply loads
   a_r12_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> !cmd_ready);

   // R12: the queue is never written when full
   a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |-> (int'(q_count) < DEPTH));

   // R9: the first pushed byte of a stream packet carries the fixed bit 3
   a_r9_sync_bit: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> q_push && q_wdata[3]);
endmodule

bind ps2_ptr_engine ps2e_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .q_push(q_push), .q_wdata(q_wdata), .q_count(q_count), .launch(launch));

// File: tb/sim_ps2_ptr_engine.sv
module sim_ps2_ptr_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_data = 8'h00;
   logic       cmd_ready;
   logic       mv_valid = 1'b0;
   logic [9:0] mv_dx = '0, mv_dy = '0, mv_dz = '0;
   logic [4:0] btn = '0;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_ready = 1'b1;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   ps2_ptr_engine u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
      .cmd_ready(cmd_ready), .mv_valid(mv_valid), .mv_dx(mv_dx), .mv_dy(mv_dy),
      .mv_dz(mv_dz), .btn(btn), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready));

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic expb(input logic [7:0] b, input string tag);
      exp_q.push_back(b);
      tag_q.push_back(tag);
   endtask

   // monitor: samples at the falling edge; a pop happens on the next rising edge
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "unexpected byte", int'(out_data), 0);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_data == e, t, int'(out_data), int'(e));
         end
      end
   end

   task automatic send(input logic [7:0] b);
      @(posedge clk); #2;
      while (!cmd_ready) begin @(posedge clk); #2; end
      cmd_valid = 1'b1; cmd_data = b;
      @(posedge clk); #2;
      cmd_valid = 1'b0;
   endtask

   task automatic move(input int dx, input int dy, input int dz);
      @(posedge clk); #2;
      mv_valid = 1'b1; mv_dx = 10'(dx); mv_dy = 10'(dy); mv_dz = 10'(dz);
      @(posedge clk); #2;
      mv_valid = 1'b0;
   endtask

   task automatic set_btn(input logic [4:0] b);
      @(posedge clk); #2;
      btn = b;
   endtask

   task automatic drain(input string tag);
      for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(posedge clk);
      repeat (20) @(posedge clk);
      check(exp_q.size() == 0, tag, exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
   endtask

   task automatic magic(input logic [7:0] mid, input string tag);
      expb(8'hFA, tag); send(8'hF3); expb(8'hFA, tag); send(8'hC8);
      expb(8'hFA, tag); send(8'hF3); expb(8'hFA, tag); send(mid);
      expb(8'hFA, tag); send(8'hF3); expb(8'hFA, tag); send(8'h50);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 idle output", out_valid, 0);
      check(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);

      expb(8'hFA, "R7 id ack"); expb(8'h00, "R1 plain id");
      send(8'hF2);
      expb(8'hFA, "R5 ack"); expb(8'h00, "R1 status"); expb(8'h02, "R1 res");
      expb(8'h64, "R1 rate");
      send(8'hE9);
      drain("R1 defaults");

      expb(8'hFE, "R2 unknown 00"); send(8'h00);
      expb(8'hFE, "R2 unknown F0"); send(8'hF0);
      expb(8'hFA, "R4 stream ack"); send(8'hEA);
      drain("R2 unknown");

      move(5, 0, 0);
      drain("R4 disabled motion dropped");

      expb(8'hFA, "R4 enable ack"); send(8'hF4);
      drain("R11 no packet when idle");

      expb(8'h28, "R9 small b0"); expb(8'h0A, "R9 small x"); expb(8'hFB, "R9 small y");
      move(10, -5, 0);
      drain("R9 small");
      expb(8'hE8, "R9 clamp b0"); expb(8'hFF, "R9 clamp x"); expb(8'h00, "R9 clamp y");
      move(400, -300, 0);
      drain("R9 clamp");
      expb(8'hD8, "R9 clamp2 b0"); expb(8'h00, "R9 clamp2 x"); expb(8'hFF, "R9 clamp2 y");
      move(-300, 300, 0);
      drain("R9 clamp2");

      expb(8'h0D, "R11 button b0"); expb(8'h00, "R11 button x"); expb(8'h00, "R11 button y");
      set_btn(5'b00101);
      drain("R11 button only");

      expb(8'hFA, "R4 scale2 ack"); send(8'hE7);
      expb(8'hFA, "R5 ack"); expb(8'h36, "R4 R5 status scaled"); expb(8'h02, "R5 res");
      expb(8'h64, "R5 rate");
      send(8'hE9);
      expb(8'hFA, "R4 scale1 ack"); send(8'hE6);
      expb(8'hFA, "R5 ack"); expb(8'h16, "R4 status unscaled"); expb(8'h02, "R5 res");
      expb(8'h64, "R5 rate");
      send(8'hE9);
      drain("R4 scaling");

      expb(8'hFA, "R3 res ack"); send(8'hE8); expb(8'hFA, "R3 res param"); send(8'h03);
      expb(8'hFA, "R3 rate ack"); send(8'hF3); expb(8'hFA, "R3 rate param"); send(8'h28);
      expb(8'hFA, "R3 ack"); expb(8'h16, "R3 status"); expb(8'h03, "R3 res");
      expb(8'h28, "R3 rate");
      send(8'hE9);
      drain("R3 params");

      // stalled output
      @(posedge clk); #2 out_ready = 1'b0;
      expb(8'hFA, "R12 ack"); expb(8'h16, "R12 status"); expb(8'h03, "R12 res");
      expb(8'h28, "R12 rate");
      send(8'hE9);
      expb(8'h0D, "R12 pkt b0"); expb(8'h01, "R12 pkt x"); expb(8'h00, "R12 pkt y");
      move(1, 0, 0);
      repeat (12) @(posedge clk);
      @(negedge clk);
      check(cmd_ready == 1'b0, "R12 ready low with queue full", cmd_ready, 0);
      check(out_valid == 1'b1, "R12 held valid", out_valid, 1);
      check(out_data == 8'hFA, "R12 held byte", out_data, 8'hFA);
      @(posedge clk); #2 out_ready = 1'b1;
      drain("R12 stall");

      expb(8'hFA, "R11 read ack"); expb(8'h0D, "R11 read b0"); expb(8'h00, "R11 read x");
      expb(8'h00, "R11 read y");
      send(8'hEB);
      drain("R11 read");

      expb(8'hFA, "R4 disable ack"); send(8'hF5);
      move(7, 0, 0);
      expb(8'hFA, "R4 enable ack"); send(8'hF4);
      drain("R4 dropped while off");
      expb(8'hFA, "R11 read ack"); expb(8'h0D, "R4 read b0"); expb(8'h00, "R4 read x");
      expb(8'h00, "R4 read y");
      send(8'hEB);
      drain("R4 read after drop");

      magic(8'h64, "R8 wheel run");
      expb(8'hFA, "R7 ack"); expb(8'h03, "R7 R8 wheel id");
      send(8'hF2);
      drain("R8 wheel");
      expb(8'h0D, "R10 b0"); expb(8'h01, "R10 x"); expb(8'h00, "R10 y");
      expb(8'hFD, "R10 wheel -3");
      move(1, 0, -3);
      drain("R10 wheel small");
      expb(8'h0D, "R10 b0"); expb(8'h00, "R10 x"); expb(8'h00, "R10 y");
      expb(8'h07, "R10 wheel clamp hi");
      move(0, 0, 20);
      drain("R10 clamp hi");
      expb(8'h0D, "R10 b0"); expb(8'h00, "R10 x"); expb(8'h00, "R10 y");
      expb(8'hF8, "R10 wheel clamp lo");
      move(0, 0, -20);
      drain("R10 clamp lo");

      magic(8'hC8, "R8 five run");
      expb(8'hFA, "R7 ack"); expb(8'h04, "R7 R8 five id");
      send(8'hF2);
      drain("R8 five");
      expb(8'h0D, "R10 five b0"); expb(8'h00, "R10 five x"); expb(8'h00, "R10 five y");
      expb(8'h30, "R10 five buttons");
      set_btn(5'b11101);
      drain("R10 five buttons");
      expb(8'h0D, "R10 five b0"); expb(8'h00, "R10 five x"); expb(8'h00, "R10 five y");
      expb(8'h3F, "R10 five wheel");
      move(0, 0, -1);
      drain("R10 five wheel");

      expb(8'hFA, "R6 default ack"); send(8'hF6);
      expb(8'hFA, "R7 ack"); expb(8'h00, "R6 id plain"); send(8'hF2);
      move(4, 0, 0);
      expb(8'hFA, "R5 ack"); expb(8'h06, "R6 status"); expb(8'h02, "R6 res");
      expb(8'h64, "R6 rate");
      send(8'hE9);
      drain("R6 defaults");

      expb(8'hFA, "R4 enable ack"); send(8'hF4);
      expb(8'hFA, "R3 rate ack"); send(8'hF3);
      expb(8'hFA, "R3 reset ack"); expb(8'hAA, "R3 reset AA"); expb(8'h00, "R3 reset 00");
      send(8'hFF);
      expb(8'hFA, "R5 ack"); expb(8'h06, "R3 status after reset"); expb(8'h02, "R3 res");
      expb(8'h64, "R3 rate");
      send(8'hE9);
      drain("R3 reset in param slot");

      expb(8'hFA, "R6 reset ack"); expb(8'hAA, "R6 reset AA"); expb(8'h00, "R6 reset 00");
      send(8'hFF);
      drain("R6 reset");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule